// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the device side of a small asynchronous-strobe DRAM model. A fast internal clock samples the active-low row strobe, column strobe, write strobe and output-enable strobe together with a multiplexed address bus. The block watches the order in which those strobes change and from that order decides what kind of memory cycle the host is running. It then latches row and column addresses, issues read and write pulses to a small storage array, drives the data output when a read is allowed to show, and keeps an internal row counter for self-addressed refresh.

Five kinds of cycle are recognised. A column strobe that is already low when the row strobe falls starts a counter-addressed refresh. A row strobe with no column strobe is a refresh of the row placed on the address pins. A column strobe that falls while the write strobe is low is an early write. A column strobe with the write strobe high is a read, and a write strobe that falls later in the same access turns it into a read-modify-write. While the row strobe stays low, each new column strobe falling edge starts a fresh access in the same row (page mode).

The array depth is set by parameters so that the model stays small. Only the order of edges is modelled; analogue timing limits are not checked.

Top module: `dram_strobe_decoder`

## Requirements
- R1: If the column strobe is sampled low at the clock where a row strobe falling edge is seen, `cycle_o` becomes 5 one clock later, `row_o` takes the old refresh counter value and `refresh_row_o` takes that value plus one. A column strobe that falls while the row strobe is high changes nothing by itself (`cycle_o` stays 0).
- R2: A row strobe falling edge with the column strobe high sets `cycle_o` to 1 and `row_o` to `addr`; the code stays 1 until a column strobe edge or the row strobe rises, after which `cycle_o` returns to 0. Such a cycle leaves stored data and `refresh_row_o` untouched.
- R3: A column strobe falling edge with the write strobe low sets `cycle_o` to 3 and stores `din`; `dq_oe` stays 0 through the whole access even with the output enable low.
- R4: In a read access (`cycle_o` 2) a write strobe falling edge while the column strobe is low sets `cycle_o` to 4 and stores `din` at the same location; data shown earlier in that access is the value held before the write.
- R5: Each column strobe falling edge while the row strobe is held low latches `col_o` = `addr[7:0]` and starts a new access in the same row; the array location is {low 3 bits of `row_o`, low 3 bits of `col_o`} with default parameters.
- R6: `dq_oe` is 1 one clock after the column and output enable strobes are both sampled low in a read or read-modify-write cycle, and 0 one clock after either is sampled high; `dq_out` shows the stored value while `dq_oe` is 1 and is 0 otherwise.
- R7: The refresh counter is 9 bits, wraps from 511 to 0, and changes only on entry to a counter-addressed refresh.
- R8: While `rst` is high, `cycle_o`, `row_o`, `col_o`, `refresh_row_o`, `dq_oe` and `dq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data output enable |
| cycle_o | output | 3 | Cycle code: 0 idle, 1 row refresh, 2 read, 3 early write, 4 read-modify-write, 5 counter refresh |
| row_o | output | ADDR_W | Latched row |
| col_o | output | ADDR_W-1 | Latched column |
| refresh_row_o | output | ADDR_W | Next row for counter-addressed refresh |

## Verification
The assertions take for granted that the strobes are synchronous to the sampling clock and change at most once per clock, and that the row strobe stays high long enough between cycles for the return to idle to be sampled. The stimulus drives every strobe on the falling clock edge, holds each level for at least one full clock, closes each row cycle before opening the next, and raises the output enable before a late write strobe so the read-modify-write sequence keeps its order. Random pages mix reads, early writes and read-modify-writes over random rows and columns on top of directed refresh, counter wrap and output-gating cases.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_ROWREF = 3'd1,
        CYC_READ   = 3'd2,
        CYC_EWRITE = 3'd3,
        CYC_RMW    = 3'd4,
        CYC_CBR    = 3'd5
    } cyc_e;

    typedef struct packed {
        logic fall;
        logic rise;
        logic low_held;
    } edge_s;

    // Cycles in which the stored word may appear on the data output
    function automatic logic shows_data(cyc_e c);
        return (c == CYC_READ) || (c == CYC_RMW);
    endfunction

endpackage

// File: rtl/dsd_strobe_edges.sv
module dsd_strobe_edges #(
    parameter int N = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0]              strobe_n,
    output dsd_pkg::edge_s [N-1:0]    ev
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= strobe_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev[i].fall     =  prev_q[i] & ~strobe_n[i];
        assign ev[i].rise     = ~prev_q[i] &  strobe_n[i];
        assign ev[i].low_held = ~prev_q[i] & ~strobe_n[i];
    end
endmodule

// File: rtl/dsd_cycle_ctrl.sv
module dsd_cycle_ctrl
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int COL_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_s             ras_ev,
    input  edge_s             cas_ev,
    input  edge_s             we_ev,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output cyc_e              cyc_q,
    output logic [ADDR_W-1:0] row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [ADDR_W-1:0] ref_q,
    output logic              dq_en_q,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_row,
    output logic [COL_W-1:0]  acc_col
);
    cyc_e              cyc_d;
    logic [ADDR_W-1:0] row_d, ref_d;
    logic [COL_W-1:0]  col_d;
    logic              dq_en_d;

    always_comb begin
        cyc_d   = cyc_q;
        row_d   = row_q;
        col_d   = col_q;
        ref_d   = ref_q;
        acc_rd  = 1'b0;
        acc_wr  = 1'b0;
        if (ras_ev.rise) begin
            cyc_d = CYC_IDLE;
        end else if (ras_ev.fall) begin
            if (!cas_n) begin
                cyc_d = CYC_CBR;
                row_d = ref_q;
                ref_d = ref_q + 1'b1;
            end else begin
                cyc_d = CYC_ROWREF;
                row_d = addr;
            end
        end else if (ras_ev.low_held && cyc_q != CYC_CBR) begin
            if (cas_ev.fall) begin
                col_d = addr[COL_W-1:0];
                if (!we_n) begin
                    cyc_d  = CYC_EWRITE;
                    acc_wr = 1'b1;
                end else begin
                    cyc_d  = CYC_READ;
                    acc_rd = 1'b1;
                end
            end else if (cyc_q == CYC_READ && !cas_n && we_ev.fall) begin
                cyc_d  = CYC_RMW;
                acc_wr = 1'b1;
            end
        end
        acc_row = row_d;
        acc_col = col_d;
        dq_en_d = shows_data(cyc_d) && !cas_n && !oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= CYC_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            ref_q   <= '0;
            dq_en_q <= 1'b0;
        end else begin
            cyc_q   <= cyc_d;
            row_q   <= row_d;
            col_q   <= col_d;
            ref_q   <= ref_d;
            dq_en_q <= dq_en_d;
        end
    end
endmodule

// File: rtl/dsd_cell_array.sv
module dsd_cell_array #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    localparam int COL_W   = ADDR_W - 1,
    localparam int IDX_W   = ROW_BITS + COL_BITS,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx = {ROW_BITS'(row), COL_BITS'(col)};

    always_ff @(posedge clk) begin
        if (wr) cells[idx] <= wdata;
        if (rd) rdata      <= cells[idx];
    end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int MEM_ROW_BITS = 3,
    parameter int MEM_COL_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [2:0]        cycle_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [ADDR_W-2:0] col_o,
    output logic [ADDR_W-1:0] refresh_row_o
);
    import dsd_pkg::*;

    localparam int COL_W = ADDR_W - 1;
    localparam int ST_RAS = 2, ST_CAS = 1, ST_WE = 0;

    edge_s [2:0]        ev;
    cyc_e               cyc;
    logic               acc_rd, acc_wr;
    logic [ADDR_W-1:0]  acc_row;
    logic [COL_W-1:0]   acc_col;
    logic [DATA_W-1:0]  rdata;

    dsd_strobe_edges #(.N(3)) u_edges (
        .clk      (clk),
        .rst      (rst),
        .strobe_n ({ras_n, cas_n, we_n}),
        .ev       (ev)
    );

    dsd_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ras_ev  (ev[ST_RAS]),
        .cas_ev  (ev[ST_CAS]),
        .we_ev   (ev[ST_WE]),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .cyc_q   (cyc),
        .row_q   (row_o),
        .col_q   (col_o),
        .ref_q   (refresh_row_o),
        .dq_en_q (dq_oe),
        .acc_rd  (acc_rd),
        .acc_wr  (acc_wr),
        .acc_row (acc_row),
        .acc_col (acc_col)
    );

    dsd_cell_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ROW_BITS (MEM_ROW_BITS),
        .COL_BITS (MEM_COL_BITS)
    ) u_array (
        .clk   (clk),
        .rd    (acc_rd),
        .wr    (acc_wr),
        .row   (acc_row),
        .col   (acc_col),
        .wdata (din),
        .rdata (rdata)
    );

    assign cycle_o = cyc;
    assign dq_out  = dq_oe ? rdata : '0;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cas_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic [2:0]        cycle_o,
    input logic [ADDR_W-1:0] row_o,
    input logic [ADDR_W-2:0] col_o,
    input logic [ADDR_W-1:0] refresh_row_o
);
    import dsd_pkg::*;

    AST_CBR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == CYC_CBR && $past(cycle_o) != CYC_CBR)
        |-> (refresh_row_o == ADDR_W'($past(refresh_row_o) + 1'b1)) && (row_o == $past(refresh_row_o))); // R1

    AST_ROWREF_ROW: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == CYC_ROWREF && $past(cycle_o) == CYC_IDLE) |-> row_o == $past(addr)); // R2

    AST_EWRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cycle_o == CYC_EWRITE |-> !dq_oe); // R3

    AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == CYC_RMW && $past(cycle_o) != CYC_RMW) |-> $past(cycle_o) == CYC_READ); // R4

    AST_COL_ON_CAS: assert property (@(posedge clk) disable iff (rst)
        (col_o != $past(col_o)) |-> !$past(cas_n)); // R5

    AST_DQ_GATED: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!$past(cas_n) && !$past(oe_n))); // R6

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cycle_o == CYC_CBR && $past(cycle_o) != CYC_CBR) |-> $stable(refresh_row_o)); // R7
endmodule

bind dram_strobe_decoder dsd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cas_n         (cas_n),
    .oe_n          (oe_n),
    .addr          (addr),
    .dq_oe         (dq_oe),
    .cycle_o       (cycle_o),
    .row_o         (row_o),
    .col_o         (col_o),
    .refresh_row_o (refresh_row_o)
);

// File: tb/dram_strobe_decoder_tb_top.sv
module dram_strobe_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int MRB = 3;
    localparam int MCB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;
    logic [2:0] cycle_o;
    logic [AW-1:0] row_o;
    logic [AW-2:0] col_o;
    logic [AW-1:0] refresh_row_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [DW-1:0] mem_m [1 << (MRB + MCB)];
    logic [AW-1:0] ref_m = '0;
    logic [AW-1:0] cur_row = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW), .DATA_W(DW), .MEM_ROW_BITS(MRB), .MEM_COL_BITS(MCB)) dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe), .cycle_o(cycle_o),
        .row_o(row_o), .col_o(col_o), .refresh_row_o(refresh_row_o)
    );

    function automatic int midx(input logic [AW-1:0] r, input logic [AW-1:0] c);
        return int'({r[MRB-1:0], c[MCB-1:0]});
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ras_open(input logic [AW-1:0] r);
        addr = r; cas_n = 1'b1; ras_n = 1'b0;
        step();
        cur_row = r;
        check("R2", "cycle after row strobe", 32'(cycle_o), 32'd1);
        check("R2", "row latch", 32'(row_o), 32'(r));
    endtask

    task automatic ras_close();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step();
        check("R2", "idle after row strobe rise", 32'(cycle_o), 32'd0);
    endtask

    task automatic cas_read(input logic [AW-1:0] c, input bit drop_oe_first);
        addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
        step();
        check("R5", "read cycle code", 32'(cycle_o), 32'd2);
        check("R5", "column latch", 32'(col_o), 32'(c[AW-2:0]));
        check("R6", "dq_oe on read", 32'(dq_oe), 32'd1);
        check("R6", "read data", 32'(dq_out), 32'(mem_m[midx(cur_row, c)]));
        if (drop_oe_first) begin
            oe_n = 1'b1;
            step();
            check("R6", "dq_oe after OE rise", 32'(dq_oe), 32'd0);
            check("R6", "dq_out zero when off", 32'(dq_out), 32'd0);
            cas_n = 1'b1;
        end else begin
            cas_n = 1'b1;
            step();
            check("R6", "dq_oe after CAS rise", 32'(dq_oe), 32'd0);
            oe_n = 1'b1;
        end
        step();
    endtask

    task automatic cas_write(input logic [AW-1:0] c, input logic [DW-1:0] d);
        addr = c; din = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0;
        step();
        check("R3", "early write code", 32'(cycle_o), 32'd3);
        check("R3", "dq stays off in early write", 32'(dq_oe), 32'd0);
        mem_m[midx(cur_row, c)] = d;
        step();
        check("R3", "dq still off", 32'(dq_oe), 32'd0);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic cas_rmw(input logic [AW-1:0] c, input logic [DW-1:0] d);
        addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
        step();
        check("R4", "read phase code", 32'(cycle_o), 32'd2);
        check("R4", "old data shown first", 32'(dq_out), 32'(mem_m[midx(cur_row, c)]));
        oe_n = 1'b1;
        step();
        din = d; we_n = 1'b0;
        step();
        check("R4", "rmw code", 32'(cycle_o), 32'd4);
        check("R4", "dq off during write", 32'(dq_oe), 32'd0);
        mem_m[midx(cur_row, c)] = d;
        cas_n = 1'b1; we_n = 1'b1;
        step();
    endtask

    task automatic cbr_cycle();
        cas_n = 1'b0;
        step();
        check("R1", "CAS alone leaves idle", 32'(cycle_o), 32'd0);
        ras_n = 1'b0;
        step();
        check("R1", "counter refresh code", 32'(cycle_o), 32'd5);
        check("R1", "row from counter", 32'(row_o), 32'(ref_m));
        ref_m = ref_m + 1'b1;
        check("R7", "counter advance", 32'(refresh_row_o), 32'(ref_m));
        ras_n = 1'b1; cas_n = 1'b1;
        step();
        check("R1", "idle after refresh", 32'(cycle_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R8", "cycle in reset", 32'(cycle_o), 32'd0);
        check("R8", "dq_oe in reset", 32'(dq_oe), 32'd0);
        check("R8", "dq_out in reset", 32'(dq_out), 32'd0);
        check("R8", "row in reset", 32'(row_o), 32'd0);
        check("R8", "col in reset", 32'(col_o), 32'd0);
        check("R8", "refresh row in reset", 32'(refresh_row_o), 32'd0);
        rst = 1'b0;
        step();

        // Fill every cell with page-mode early writes
        for (int r = 0; r < (1 << MRB); r++) begin
            ras_open(AW'(r));
            for (int c = 0; c < (1 << MCB); c++) cas_write(AW'(c), DW'(r * 37 + c * 11 + 5));
            ras_close();
        end

        // Page-mode reads, both ways of ending the output
        ras_open(AW'(3));
        for (int c = 0; c < (1 << MCB); c++) cas_read(AW'(c), c[0]);
        ras_close();

        // Row-address refresh: no data or counter change
        ras_open(AW'(2));
        step();
        check("R2", "row refresh holds code", 32'(cycle_o), 32'd1);
        check("R2", "counter untouched", 32'(refresh_row_o), 32'(ref_m));
        ras_close();
        ras_open(AW'(2));
        cas_read(AW'(5), 1'b0);
        ras_close();

        // Read-modify-write then read back
        ras_open(AW'(6));
        cas_rmw(AW'(4), 8'hA5);
        cas_read(AW'(4), 1'b1);
        ras_close();

        // Counter-addressed refresh through the wrap
        for (int i = 0; i < 515; i++) begin
            if (i == 512) check("R7", "counter wrapped", 32'(ref_m), 32'd0);
            cbr_cycle();
        end
        check("R7", "counter after wrap", 32'(refresh_row_o), 32'd3);

        // Random pages
        for (int it = 0; it < 200; it++) begin
            int kind;
            kind = int'($urandom % 10);
            if (kind == 0) begin
                cbr_cycle();
            end else begin
                ras_open(AW'($urandom));
                if (kind == 1) begin
                    step();
                    check("R2", "random row refresh", 32'(cycle_o), 32'd1);
                end else begin
                    for (int p = 0; p <= int'($urandom % 4); p++) begin
                        int op;
                        logic [AW-1:0] c;
                        op = int'($urandom % 3);
                        c = AW'($urandom);
                        if (op == 0) cas_read(c, $urandom % 2 == 0);
                        else if (op == 1) cas_write(c, DW'($urandom));
                        else cas_rmw(c, DW'($urandom));
                    end
                end
                ras_close();
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule